// File: doc/BRIEF.md
# Counter Channel Byte Port

This block is the byte-wide processor side of one up/down counter channel. A processor reaches it with a chip select, a command/data select line and single-cycle read and write strobes. It writes command bytes and data bytes, and it reads back either a status byte or one byte of a multi-byte latched count. Command bytes are decoded into actions. These actions are: latch the count, load the preload value, change the index-pulse clear policy, choose a target register and byte, switch the system mode, and issue extended mode-1 commands.

Each data byte is sent out as a registered write strobe that carries a register code, a byte index and the byte. A write pointer then moves on by itself. It runs through counter, reference A and preload in mode 0, and through reference B as well in mode 1. A second pointer steps through the latch bytes on reads. A data-ready flag inside the status byte is set when the count is latched and cleared once the top latch byte has been read. The counter, the comparators and the pin routing sit outside this block and use the strobes it produces.

Top module: `chan_cpu_port`

## Requirements
- R1: After reset the block is in mode 0 (`mode1`=0), every strobe output is low, `rdata_oe` is low, the data-ready flag is 0, the write pointer is at counter low byte (`reg_wr_sel`=0, `reg_wr_byte`=0) and the latch-read pointer is at byte 0.
- R2: While `cs`=1 and `rd`=1 and `wr`=0, `rdata_oe` is 1. With `cmd_sel`=1, `rdata` is the status byte: bits 7..4 and 2..0 come from `status_ext` and bit 3 is the data-ready flag. With `cmd_sel`=0, `rdata` is latch byte k (bits 8k+7..8k) of `latch_val`, where k is the read pointer.
- R3: A command byte whose bits 7 and 4 are 0 and 1 raises `lt_stb`, and one whose bits are 1 and 0 raises `ld_stb`. The strobe lasts one cycle, starting the cycle after the write. When both bits are 0, neither strobe is raised.
- R4: In a command byte that is not an ID, a nonzero bits 6:5 field raises `ze_stb` for one cycle, with `ze_code` equal to that field (01 ignore the index pulse, 10 next pulse only, 11 every pulse). A value of 00 raises nothing.
- R5: A command byte that is not an ID sets the write pointer. Bits 3:2 pick the register: 00 counter (code 0), 01 reference A (code 1), 1x preload (code 2) in mode 0. Bits 1:0 pick the byte: 00 low (0), 01 middle (1), 1x high (2). The same byte index is loaded into the latch-read pointer.
- R6: Each data write gives `reg_wr_stb` for one cycle, with the current pointer and the byte. The pointer then moves on through byte 0,1,2 of codes 0,1,2 in mode 0 and wraps from preload high back to counter low.
- R7: In mode 1, register field 10 selects preload and 11 selects reference B (code 3). The data sequence runs on through reference B bytes 0..2 before it wraps to counter low.
- R8: Command 0x90 selects mode 0 and 0x91 selects mode 1. Both return the write pointer to counter low and the read pointer to byte 0. Commands 0x92..0x9F raise `id_stb` for one cycle, with `id_code` equal to the low nibble, in mode 1 only. In mode 0 they have no effect.
- R9: A command with bits 7 and 4 both 1 and bits 6:5 not 00 is inhibited. It raises no strobe and leaves both pointers unchanged.
- R10: Each latch read moves the read pointer 0→1→2→0.
- R11: The data-ready flag is set the cycle after `lt_stb` or `ext_latch` is high. It clears after a latch read of byte 2. A set and a clear in the same cycle leave the flag set.
- R12: An access with `cs`=0, or with `rd` and `wr` both high, has no effect. `rdata_oe` stays 0 and no strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Channel select |
| cmd_sel | input | 1 | 1: command write / status read; 0: data write / latch read |
| rd | input | 1 | Read strobe, one cycle per byte |
| wr | input | 1 | Write strobe, one cycle per byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid while `rdata_oe` |
| rdata_oe | output | 1 | Bus drive enable; low means high-impedance |
| status_ext | input | 8 | External status bits (bit 3 unused) |
| latch_val | input | 8*NBYTES | Latched count from the channel |
| ext_latch | input | 1 | Pulse: latch register loaded by an outside source |
| mode1 | output | 1 | System mode, 1 = mode 1 |
| ld_stb | output | 1 | Load preload into counter |
| lt_stb | output | 1 | Latch counter |
| ze_stb | output | 1 | Index-pulse policy update |
| ze_code | output | 2 | New index-pulse policy |
| id_stb | output | 1 | Extended mode-1 command |
| id_code | output | 4 | Extended command low nibble |
| reg_wr_stb | output | 1 | Data byte write |
| reg_wr_sel | output | 2 | Target: 0 counter, 1 ref A, 2 preload, 3 ref B |
| reg_wr_byte | output | $clog2(NBYTES) | Target byte index |
| reg_wr_data | output | 8 | Byte to write |

## Verification
The bench builds the block with the default NBYTES of 3, the width of a 24-bit counter. With that value both full wrap points can be reached: the 9-byte data sequence in mode 0 and the 12-byte sequence in mode 1. It also brings within reach the high-byte read that clears the data-ready flag. `latch_val` holds three different bytes, and `status_ext` drives bit 3 high, so the tests can tell a wrong read byte, and a leaked external bit in place of the data-ready flag, from correct behaviour.

// File: rtl/chan_cpu_port.sv
module chan_cpu_port #(
  parameter int NBYTES = 3,
  localparam int BW = $clog2(NBYTES),
  localparam int LW = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          cmd_sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_oe,
  input  logic [7:0]    status_ext,
  input  logic [LW-1:0] latch_val,
  input  logic          ext_latch,
  output logic          mode1,
  output logic          ld_stb,
  output logic          lt_stb,
  output logic          ze_stb,
  output logic [1:0]    ze_code,
  output logic          id_stb,
  output logic [3:0]    id_code,
  output logic          reg_wr_stb,
  output logic [1:0]    reg_wr_sel,
  output logic [BW-1:0] reg_wr_byte,
  output logic [7:0]    reg_wr_data
);

  logic [1:0]    ws;
  logic [BW-1:0] wb, rb;
  logic          dtr;
  logic [7:0]    lat_byte;

  wire rd_ok  = cs & rd & ~wr;
  wire wr_ok  = cs & wr & ~rd;
  wire cmd_wr = wr_ok & cmd_sel;
  wire dat_wr = wr_ok & ~cmd_sel;
  wire lat_rd = rd_ok & ~cmd_sel;

  wire is_id   = wdata[7] & wdata[4];
  wire id_form = is_id & (wdata[6:5] == 2'b00);

  wire [1:0]    rs_sel   = wdata[3] ? {1'b1, mode1 & wdata[2]} : {1'b0, wdata[2]};
  wire [BW-1:0] bs_byte  = wdata[1] ? BW'(NBYTES - 1) : BW'(wdata[0]);
  wire [1:0]    last_sel = mode1 ? 2'd3 : 2'd2;
  wire          wb_end   = (wb == BW'(NBYTES - 1));
  wire          rb_end   = (rb == BW'(NBYTES - 1));

  always_comb lat_byte = latch_val[{rb, 3'b000} +: 8];

  assign rdata_oe = rd_ok;
  assign rdata    = !rd_ok ? 8'h00
                  : cmd_sel ? {status_ext[7:4], dtr, status_ext[2:0]}
                  : lat_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1       <= 1'b0;
      ws          <= '0;
      wb          <= '0;
      rb          <= '0;
      dtr         <= 1'b0;
      ld_stb      <= 1'b0;
      lt_stb      <= 1'b0;
      ze_stb      <= 1'b0;
      ze_code     <= '0;
      id_stb      <= 1'b0;
      id_code     <= '0;
      reg_wr_stb  <= 1'b0;
      reg_wr_sel  <= '0;
      reg_wr_byte <= '0;
      reg_wr_data <= '0;
    end else begin
      ld_stb     <= 1'b0;
      lt_stb     <= 1'b0;
      ze_stb     <= 1'b0;
      id_stb     <= 1'b0;
      reg_wr_stb <= 1'b0;

      if (cmd_wr) begin
        if (id_form) begin
          if (wdata[3:1] == 3'b000) begin
            mode1 <= wdata[0];
            ws    <= '0;
            wb    <= '0;
            rb    <= '0;
          end else if (mode1) begin
            id_stb  <= 1'b1;
            id_code <= wdata[3:0];
          end
        end else if (!is_id) begin
          ld_stb <= wdata[7];
          lt_stb <= wdata[4];
          if (wdata[6:5] != 2'b00) begin
            ze_stb  <= 1'b1;
            ze_code <= wdata[6:5];
          end
          ws <= rs_sel;
          wb <= bs_byte;
          rb <= bs_byte;
        end
      end

      if (dat_wr) begin
        reg_wr_stb  <= 1'b1;
        reg_wr_sel  <= ws;
        reg_wr_byte <= wb;
        reg_wr_data <= wdata;
        if (wb_end) begin
          wb <= '0;
          ws <= (ws == last_sel) ? 2'd0 : ws + 2'd1;
        end else begin
          wb <= wb + BW'(1);
        end
      end

      if (lat_rd) rb <= rb_end ? '0 : rb + BW'(1);

      if (lt_stb || ext_latch) dtr <= 1'b1;
      else if (lat_rd && rb_end) dtr <= 1'b0;
    end
  end

endmodule

// File: rtl/chan_cpu_port_chk.sv
module chan_cpu_port_chk #(
  parameter int NBYTES = 3,
  localparam int BW = $clog2(NBYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          cmd_sel,
  input logic          rd,
  input logic          wr,
  input logic [7:0]    wdata,
  input logic          ext_latch,
  input logic          mode1,
  input logic          ld_stb,
  input logic          lt_stb,
  input logic          reg_wr_stb,
  input logic [1:0]    reg_wr_sel,
  input logic          dtr,
  input logic [BW-1:0] rb
);

  // R3
  cmd_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb || lt_stb) |-> $past(cs && wr && !rd && cmd_sel));

  // R6
  data_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_stb |-> $past(cs && wr && !rd && !cmd_sel));

  // R7
  refb_mode1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_stb && reg_wr_sel == 2'd3) |-> mode1);

  // R8
  mode0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !rd && cmd_sel && wdata == 8'h90) |=> !mode1);

  // R11
  dtr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && !cmd_sel && rb == BW'(NBYTES - 1) && !lt_stb && !ext_latch) |=> !dtr);

endmodule

bind chan_cpu_port chan_cpu_port_chk #(.NBYTES(NBYTES)) u_chan_cpu_port_chk (.*);

// File: tb/test_chan_cpu_port.sv
module test_chan_cpu_port;
  localparam int NBYTES = 3;
  localparam int BW = $clog2(NBYTES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, cmd_sel = 0, rd = 0, wr = 0, ext_latch = 0;
  logic [7:0] wdata = 0;
  logic [7:0] status_ext = 8'b1010_1101;
  logic [23:0] latch_val = 24'hA5C33C;
  logic [7:0] rdata;
  logic rdata_oe, mode1, ld_stb, lt_stb, ze_stb, id_stb, reg_wr_stb;
  logic [1:0] ze_code, reg_wr_sel;
  logic [3:0] id_code;
  logic [BW-1:0] reg_wr_byte;
  logic [7:0] reg_wr_data;

  int tests_run = 0, tests_failed = 0;
  bit done = 0;

  chan_cpu_port #(.NBYTES(NBYTES)) i_chan_cpu_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .cmd_sel(cmd_sel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .status_ext(status_ext),
    .latch_val(latch_val), .ext_latch(ext_latch), .mode1(mode1),
    .ld_stb(ld_stb), .lt_stb(lt_stb), .ze_stb(ze_stb), .ze_code(ze_code),
    .id_stb(id_stb), .id_code(id_code), .reg_wr_stb(reg_wr_stb),
    .reg_wr_sel(reg_wr_sel), .reg_wr_byte(reg_wr_byte), .reg_wr_data(reg_wr_data)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic c, input logic cd, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    cs = c; cmd_sel = cd; rd = r; wr = w; wdata = d;
    @(negedge clk);
    cs = 0; rd = 0; wr = 0;
  endtask

  task automatic wcmd(input logic [7:0] d); cycle(1, 1, 0, 1, d); endtask
  task automatic wdat(input logic [7:0] d); cycle(1, 0, 0, 1, d); endtask

  task automatic rbus(input logic cd, output logic [7:0] v, output logic oe);
    @(negedge clk);
    cs = 1; cmd_sel = cd; rd = 1;
    #1 v = rdata; oe = rdata_oe;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic chk_dat(input string tag, input logic [7:0] d, input int s, input int b);
    wdat(d);
    chk({tag, " stb"}, reg_wr_stb, 1);
    chk({tag, " sel"}, reg_wr_sel, s);
    chk({tag, " byte"}, reg_wr_byte, b);
    chk({tag, " data"}, reg_wr_data, d);
  endtask

  task automatic t_reset;
    logic [7:0] v; logic oe;
    chk("R1 oe", rdata_oe, 0);
    chk("R1 mode", mode1, 0);
    chk("R1 strobes", {ld_stb, lt_stb, ze_stb, id_stb, reg_wr_stb}, 0);
    rbus(1, v, oe);
    chk("R2 oe status", oe, 1);
    chk("R1 R2 status dtr0", v, 8'hA5);
    rbus(0, v, oe);
    chk("R1 R2 latch low", v, 8'h3C);
    rbus(0, v, oe);
    chk("R10 latch mid", v, 8'hC3);
    rbus(0, v, oe);
    chk("R10 latch high", v, 8'hA5);
    rbus(0, v, oe);
    chk("R10 latch wrap", v, 8'h3C);
    chk_dat("R1 ptr start", 8'h11, 0, 0);
  endtask

  task automatic t_seq_mode0;
    wcmd(8'h00);
    for (int i = 0; i < 9; i++) chk_dat("R6 seq", 8'(8'h20 + i), i / 3, i % 3);
    chk_dat("R6 wrap", 8'h55, 0, 0);
    wcmd(8'h0D);
    chk_dat("R5 rs11 mode0", 8'h01, 2, 1);
    wcmd(8'h06);
    chk_dat("R5 refA high", 8'h02, 1, 2);
    wcmd(8'h03);
    chk_dat("R5 bs11 high", 8'h03, 0, 2);
  endtask

  task automatic t_mode1;
    wcmd(8'h91);
    chk("R8 mode1 set", mode1, 1);
    for (int i = 0; i < 12; i++) chk_dat("R7 seq", 8'(8'h40 + i), i / 3, i % 3);
    chk_dat("R7 wrap", 8'h66, 0, 0);
    wcmd(8'h0C);
    chk_dat("R7 refB", 8'h04, 3, 0);
    wcmd(8'h08);
    chk_dat("R7 preload", 8'h05, 2, 0);
    wcmd(8'h9B);
    chk("R8 id stb", id_stb, 1);
    chk("R8 id code", id_code, 4'hB);
    wcmd(8'h0A);
    wcmd(8'h90);
    chk("R8 mode0 set", mode1, 0);
    chk_dat("R8 ptr reset", 8'h06, 0, 0);
    wcmd(8'h9B);
    chk("R8 id ignored mode0", id_stb, 0);
  endtask

  task automatic t_cmds;
    wcmd(8'h10);
    chk("R3 latch", {lt_stb, ld_stb}, 2'b10);
    @(negedge clk);
    chk("R3 one cycle", lt_stb, 0);
    wcmd(8'h80);
    chk("R3 load", {lt_stb, ld_stb}, 2'b01);
    wcmd(8'h00);
    chk("R3 none", {lt_stb, ld_stb}, 2'b00);
    wcmd(8'h40);
    chk("R4 ze stb", ze_stb, 1);
    chk("R4 ze code", ze_code, 2);
    wcmd(8'h60);
    chk("R4 ze every", ze_code, 3);
    wcmd(8'h00);
    chk("R4 ze keep", ze_stb, 0);
  endtask

  task automatic t_inhibit;
    wcmd(8'h05);
    wcmd(8'hB0);
    chk("R9 no strobe", {ld_stb, lt_stb, ze_stb, id_stb}, 0);
    chk_dat("R9 ptr kept", 8'h07, 1, 1);
  endtask

  task automatic t_latch;
    logic [7:0] v; logic oe;
    wcmd(8'h02);
    rbus(0, v, oe);
    chk("R5 R10 bs high", v, 8'hA5);
    rbus(0, v, oe);
    chk("R10 wrap low", v, 8'h3C);
    rbus(1, v, oe);
    chk("R11 dtr clear after high", v[3], 0);
    wcmd(8'h10);
    rbus(1, v, oe);
    chk("R11 dtr set", v, 8'hAD);
    rbus(0, v, oe);
    rbus(0, v, oe);
    rbus(1, v, oe);
    chk("R11 dtr held", v[3], 1);
    rbus(0, v, oe);
    chk("R11 high byte", v, 8'hA5);
    rbus(1, v, oe);
    chk("R11 dtr cleared", v[3], 0);
    @(negedge clk); ext_latch = 1;
    @(negedge clk); ext_latch = 0;
    rbus(1, v, oe);
    chk("R11 ext latch", v[3], 1);
  endtask

  task automatic t_ignore;
    logic [7:0] v; logic oe;
    cycle(0, 1, 0, 1, 8'h10);
    chk("R12 cs low cmd", lt_stb, 0);
    cycle(0, 0, 0, 1, 8'h77);
    chk("R12 cs low data", reg_wr_stb, 0);
    @(negedge clk); cs = 0; cmd_sel = 1; rd = 1;
    #1 chk("R12 cs low read oe", rdata_oe, 0);
    @(negedge clk); rd = 0;
    @(negedge clk); cs = 1; cmd_sel = 1; rd = 1; wr = 1; wdata = 8'h10;
    #1 chk("R12 rd wr oe", rdata_oe, 0);
    @(negedge clk); cs = 0; rd = 0; wr = 0;
    chk("R12 rd wr strobe", lt_stb, 0);
    wcmd(8'h00);
    chk_dat("R12 ptr kept", 8'h08, 0, 0);
    rbus(1, v, oe);
    chk("R12 oe on read", oe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_seq_mode0;
    t_mode1;
    t_cmds;
    t_inhibit;
    t_latch;
    t_ignore;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule